// File: doc/BRIEF.md
# Filtered translation-event performance counter bank

This block holds a set of event counters that sit beside an address-translation unit and count the translation events it reports. The slots are grouped into banks, and each slot is reached through a small register port by bank index, counter index and function offset. Each cycle the translation logic drives a vector of event pulses. With each vector come three 16-bit tags for that transaction: a requester ID (bus/device/function), a process address-space ID and a domain ID.

Each slot has an 8-bit source code that picks one event line. A zero code parks the slot. Software arms a slot by writing a non-zero code and disarms it by writing zero. The count register cannot be cleared. It only wraps, so software measures an interval by taking the difference of two reads. Three filters qualify each event, one per tag. Each filter has its own enable, match value and mask. An event is counted only when every enabled filter accepts the tags of the cycle.

Top module: `xpc_bank`

## Requirements
- R1: A slot whose source code S lies in 1..NUM_EVT-1 counts every cycle in which evt_i[S] is high and all its enabled filters match. Event line 5 carries the total of translated peripheral memory operations. A code of NUM_EVT or more selects no event and never counts.
- R2: The source code is at function offset 0x08, in bits [7:0], and reads back zero-extended. Its reset value is 0.
- R3: While a slot's source code is 0, its count does not change, whatever events arrive.
- R4: The count is at function offset 0x00 and is CNT_W bits wide (default 48). It reads back zero-extended and resets to 0. Writes to it are ignored. It rises by exactly one per counted cycle and wraps from all-ones to zero.
- R5: A filter accepts a tag when ((tag XOR match) AND mask) equals zero. A filter whose enable bit is clear always accepts.
- R6: The filter registers sit at 0x10 (requester ID), 0x18 (PASID) and 0x20 (domain ID). Each holds match in [15:0], mask in [31:16] and enable in bit 32, and reads back the same. All reset to 0.
- R7: rdata_o and err_o take the result of a request at the clock edge that samples it, so they are visible in the following cycle. rdata_o keeps the last read result through writes and idle cycles. Within a valid slot, any other offset reads zero, ignores writes and raises no error.
- R8: A request with bank_i >= NUM_BANKS or cntr_i >= CNTRS_PER_BANK returns zero on a read and changes no slot on a write. Either kind sets err_o for the one cycle after the request.
- R9: An event and a configuration write in the same cycle are judged with the configuration held before the write. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Per-cycle event pulses, one line per source code |
| req_id_i | input | 16 | Requester ID tag of this cycle's transaction |
| pasid_i | input | 16 | Process address-space ID tag |
| dom_id_i | input | 16 | Domain ID tag |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| bank_i | input | 8 | Bank index |
| cntr_i | input | 8 | Counter index within the bank |
| fn_i | input | 8 | Function register offset |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, one cycle after a read request |
| err_o | output | 1 | Out-of-range pulse, one cycle after the request |

## Verification
Every result of this block is due exactly one cycle after its stimulus. The edge that samples an event raises the count. The edge that samples a read loads rdata_o and err_o. A configuration write governs only the events of later edges. The bench drives all inputs at the falling edge and keeps a behavioural model that applies the same one-edge latency. It compares rdata_o and err_o against the model at every falling edge. A read issued right after a burst of events must therefore show the whole burst, and a read in the same cycle as an event must show the count from before that event. The directed reads sample at the falling edge after the request edge and compare against values worked out by hand.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  localparam int TAG_W   = 16;
  localparam int FN_W    = 8;
  localparam int DATA_W  = 64;
  localparam int SRC_W   = 8;
  localparam int NUM_FLT = 3;
  localparam int FN_STRIDE = 8;

  localparam logic [FN_W-1:0] FN_COUNT    = 8'h00;
  localparam logic [FN_W-1:0] FN_SRC      = 8'h08;
  localparam logic [FN_W-1:0] FN_FLT_BASE = 8'h10;

  // filter order: requester, pasid, domain
  localparam int FLT_RID   = 0;
  localparam int FLT_PASID = 1;
  localparam int FLT_DOM   = 2;

  typedef struct packed {
    logic              en;
    logic [TAG_W-1:0]  mask;
    logic [TAG_W-1:0]  match;
  } flt_cfg_t;

  localparam int FLT_CFG_W = $bits(flt_cfg_t);

  // packed so that tag f sits at [f*TAG_W +: TAG_W]
  typedef struct packed {
    logic [TAG_W-1:0] dom;
    logic [TAG_W-1:0] pasid;
    logic [TAG_W-1:0] rid;
  } tag_set_t;

  function automatic logic [FN_W-1:0] flt_fn_off(input int f);
    return FN_FLT_BASE + FN_W'(f * FN_STRIDE);
  endfunction
endpackage

// File: rtl/xpc_filter.sv
module xpc_filter
  import xpc_pkg::*;
(
  input  flt_cfg_t         cfg_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             pass_o
);
  logic [TAG_W-1:0] diff;

  assign diff   = (tag_i ^ cfg_i.match) & cfg_i.mask;
  assign pass_o = !cfg_i.en || (diff == '0);
endmodule

// File: rtl/xpc_regdec.sv
module xpc_regdec #(
  parameter int NUM_BANKS      = 2,
  parameter int CNTRS_PER_BANK = 4,
  parameter int IDX_W          = 8,
  localparam int NUM_SLOTS     = NUM_BANKS * CNTRS_PER_BANK,
  localparam int SLOT_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     bank_i,
  input  logic [IDX_W-1:0]     cntr_i,
  output logic                 in_range_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [NUM_SLOTS-1:0] wr_slot_o
);
  // both counts must stay below 2**IDX_W
  localparam logic [IDX_W-1:0] BANK_LIM = IDX_W'(NUM_BANKS);
  localparam logic [IDX_W-1:0] CNTR_LIM = IDX_W'(CNTRS_PER_BANK);

  logic [2*IDX_W-1:0] flat;

  always_comb begin
    in_range_o = (bank_i < BANK_LIM) && (cntr_i < CNTR_LIM);
    flat = {{IDX_W{1'b0}}, bank_i} * {{IDX_W{1'b0}}, CNTR_LIM}
         + {{IDX_W{1'b0}}, cntr_i};
    slot_o = in_range_o ? flat[SLOT_W-1:0] : '0;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_wsel
    assign wr_slot_o[s] = req_i && we_i && in_range_o && (slot_o == SLOT_W'(s));
  end
endmodule

// File: rtl/xpc_slot.sv
module xpc_slot
  import xpc_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 48
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_EVT-1:0]           evt_i,
  input  tag_set_t                     tags_i,
  input  logic                         wr_i,
  input  logic [FN_W-1:0]              fn_i,
  input  logic [FLT_CFG_W-1:0]         wdata_i,
  output logic [SRC_W-1:0]             src_o,
  output flt_cfg_t [NUM_FLT-1:0]       flt_o,
  output logic [CNT_W-1:0]             cnt_o
);
  // NUM_EVT must not exceed 2**SRC_W
  localparam int EVT_IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [SRC_W-1:0] SRC_MAX = SRC_W'(NUM_EVT - 1);

  logic [SRC_W-1:0]       src_q;
  flt_cfg_t [NUM_FLT-1:0] flt_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [NUM_FLT-1:0]     flt_pass;
  logic                   evt_sel;
  logic                   hit;

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
    xpc_filter u_filter (
      .cfg_i  (flt_q[f]),
      .tag_i  (tags_i[f*TAG_W +: TAG_W]),
      .pass_o (flt_pass[f])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               flt_q[f] <= '0;
      else if (wr_i && (fn_i == flt_fn_off(f)))  flt_q[f] <= wdata_i;
    end
  end

  always_comb begin
    evt_sel = 1'b0;
    if ((src_q != '0) && (src_q <= SRC_MAX)) evt_sel = evt_i[src_q[EVT_IDX_W-1:0]];
  end

  assign hit = evt_sel && (&flt_pass);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         src_q <= '0;
    else if (wr_i && (fn_i == FN_SRC))   src_q <= wdata_i[SRC_W-1:0];
  end

  // no write path: only wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (hit) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign src_o = src_q;
  assign flt_o = flt_q;
  assign cnt_o = cnt_q;

  AST_PARKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == '0) |=> (cnt_q == $past(cnt_q)))
    else $error("parked slot counted"); // R3

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)))
    else $error("count moved by other than one"); // R4

  AST_FILTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&flt_pass) |=> (cnt_q == $past(cnt_q)))
    else $error("filtered event counted"); // R5

  AST_SRC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (fn_i == FN_SRC)) |=> (src_q == $past(wdata_i[SRC_W-1:0])))
    else $error("source code not loaded"); // R2
endmodule

// File: rtl/xpc_bank.sv
module xpc_bank
  import xpc_pkg::*;
#(
  parameter int NUM_BANKS      = 2,
  parameter int CNTRS_PER_BANK = 4,
  parameter int NUM_EVT        = 16,
  parameter int CNT_W          = 48,
  parameter int IDX_W          = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [TAG_W-1:0]   req_id_i,
  input  logic [TAG_W-1:0]   pasid_i,
  input  logic [TAG_W-1:0]   dom_id_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   bank_i,
  input  logic [IDX_W-1:0]   cntr_i,
  input  logic [FN_W-1:0]    fn_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o
);
  localparam int NUM_SLOTS = NUM_BANKS * CNTRS_PER_BANK;
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDX_W-1:0] BANK_LIM = IDX_W'(NUM_BANKS);
  localparam logic [IDX_W-1:0] CNTR_LIM = IDX_W'(CNTRS_PER_BANK);

  tag_set_t                                tags;
  logic                                    in_range;
  logic [SLOT_W-1:0]                       slot_idx;
  logic [NUM_SLOTS-1:0]                    wr_slot;
  logic [NUM_SLOTS-1:0][SRC_W-1:0]         src_all;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]         cnt_all;
  flt_cfg_t [NUM_SLOTS-1:0][NUM_FLT-1:0]   flt_all;
  logic [DATA_W-1:0]                       rd_word;
  logic [DATA_W-1:0]                       rdata_q;
  logic                                    err_q;
  logic                                    unused_wdata;

  assign tags = {dom_id_i, pasid_i, req_id_i};
  assign unused_wdata = ^wdata_i[DATA_W-1:FLT_CFG_W];

  xpc_regdec #(
    .NUM_BANKS      (NUM_BANKS),
    .CNTRS_PER_BANK (CNTRS_PER_BANK),
    .IDX_W          (IDX_W)
  ) u_regdec (
    .req_i      (req_i),
    .we_i       (we_i),
    .bank_i     (bank_i),
    .cntr_i     (cntr_i),
    .in_range_o (in_range),
    .slot_o     (slot_idx),
    .wr_slot_o  (wr_slot)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    xpc_slot #(
      .NUM_EVT (NUM_EVT),
      .CNT_W   (CNT_W)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i),
      .tags_i  (tags),
      .wr_i    (wr_slot[s]),
      .fn_i    (fn_i),
      .wdata_i (wdata_i[FLT_CFG_W-1:0]),
      .src_o   (src_all[s]),
      .flt_o   (flt_all[s]),
      .cnt_o   (cnt_all[s])
    );
  end

  always_comb begin
    rd_word = '0;
    if (fn_i == FN_COUNT)    rd_word = DATA_W'(cnt_all[slot_idx]);
    else if (fn_i == FN_SRC) rd_word = DATA_W'(src_all[slot_idx]);
    for (int f = 0; f < NUM_FLT; f++) begin
      if (fn_i == flt_fn_off(f)) rd_word = DATA_W'(flt_all[slot_idx][f]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= req_i && !in_range;
      if (req_i && !we_i) rdata_q <= in_range ? rd_word : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(req_i) && (($past(bank_i) >= BANK_LIM) || ($past(cntr_i) >= CNTR_LIM))))
    else $error("error flag without bad index"); // R8

  AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ((bank_i >= BANK_LIM) || (cntr_i >= CNTR_LIM))) |=> err_o)
    else $error("bad index not flagged"); // R8

  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(we_i)) |-> (rdata_o == '0))
    else $error("out-of-range read returned data"); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> $stable(rdata_o))
    else $error("read data moved without a read"); // R7
endmodule

// File: tb/xpc_bank_bench.sv
module xpc_bank_bench;
  localparam int NB = 2;
  localparam int NC = 4;
  localparam int NE = 8;
  localparam int CW = 10;
  localparam int NS = NB * NC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic [15:0]   rid = '0, pasid = '0, dom = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    bank = '0, cntr = '0, fn = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic          err;

  always #10 clk = ~clk;

  xpc_bank #(
    .NUM_BANKS(NB), .CNTRS_PER_BANK(NC), .NUM_EVT(NE), .CNT_W(CW)
  ) u_xpc_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_id_i(rid), .pasid_i(pasid),
    .dom_id_i(dom), .req_i(req), .we_i(we), .bank_i(bank), .cntr_i(cntr),
    .fn_i(fn), .wdata_i(wdata), .rdata_o(rdata), .err_o(err)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint unsigned m_cnt [NS];
  logic [7:0]      m_src [NS];
  logic [32:0]     m_flt [NS][3];
  logic [63:0]     e_rdata;
  logic            e_err;
  string           e_tag;

  function automatic bit flt_ok(input logic [32:0] c, input logic [15:0] t);
    return !c[32] || (((t ^ c[15:0]) & c[31:16]) == 16'h0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_cnt[i] = 0;
        m_src[i] = '0;
        for (int f = 0; f < 3; f++) m_flt[i][f] = '0;
      end
      e_rdata = '0;
      e_err   = 1'b0;
      e_tag   = "R7";
    end else begin
      bit inr;
      int s;
      inr = (int'(bank) < NB) && (int'(cntr) < NC);
      s   = inr ? int'(bank) * NC + int'(cntr) : 0;
      e_err = req && !inr;
      if (req && !we) begin
        if (!inr) begin
          e_rdata = '0; e_tag = "R8";
        end else begin
          case (fn)
            8'h00: begin e_rdata = m_cnt[s];               e_tag = "R4"; end
            8'h08: begin e_rdata = {56'h0, m_src[s]};      e_tag = "R2"; end
            8'h10: begin e_rdata = {31'h0, m_flt[s][0]};   e_tag = "R6"; end
            8'h18: begin e_rdata = {31'h0, m_flt[s][1]};   e_tag = "R6"; end
            8'h20: begin e_rdata = {31'h0, m_flt[s][2]};   e_tag = "R6"; end
            default: begin e_rdata = '0;                   e_tag = "R7"; end
          endcase
        end
      end else if (req) begin
        e_tag = inr ? "R9" : "R8";
      end
      // events judged with pre-write configuration (R9)
      for (int i = 0; i < NS; i++) begin
        if (m_src[i] != 0 && int'(m_src[i]) < NE && evt[m_src[i]] &&
            flt_ok(m_flt[i][0], rid) && flt_ok(m_flt[i][1], pasid) && flt_ok(m_flt[i][2], dom))
          m_cnt[i] = (m_cnt[i] + 1) % (64'd1 << CW);
      end
      if (req && we && inr) begin
        case (fn)
          8'h08: m_src[s]    = wdata[7:0];
          8'h10: m_flt[s][0] = wdata[32:0];
          8'h18: m_flt[s][1] = wdata[32:0];
          8'h20: m_flt[s][2] = wdata[32:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata == e_rdata, e_tag, rdata, e_rdata);
      chk(err == e_err, "R8", 64'(err), 64'(e_err));
    end
  end

  task automatic wr(input int b, input int c, input logic [7:0] f, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; bank = 8'(b); cntr = 8'(c); fn = f; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int b, input int c, input logic [7:0] f, input logic [63:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; bank = 8'(b); cntr = 8'(c); fn = f;
    @(negedge clk);
    req = 1'b0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic rd_oor(input int b, input int c);
    @(negedge clk);
    req = 1'b1; we = 1'b0; bank = 8'(b); cntr = 8'(c); fn = 8'h08;
    @(negedge clk);
    req = 1'b0;
    chk(rdata == 64'h0, "R8", rdata, 64'h0);
    chk(err == 1'b1, "R8", 64'(err), 64'h1);
  endtask

  task automatic pulse_m(input logic [NE-1:0] m, input int n, input logic [15:0] r, input logic [15:0] p, input logic [15:0] d);
    @(negedge clk);
    evt = m; rid = r; pasid = p; dom = d;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic pulse(input int e, input int n, input logic [15:0] r, input logic [15:0] p, input logic [15:0] d);
    pulse_m(NE'(1) << e, n, r, p, d);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata == 64'h0 && err == 1'b0, "R7", rdata, 64'h0);
    rst_n = 1'b1;

    // reset values
    rd(0, 0, 8'h00, 64'h0, "R4");
    rd(0, 0, 8'h08, 64'h0, "R2");
    rd(1, 3, 8'h10, 64'h0, "R6");

    // parked slot
    pulse(5, 10, 16'h0, 16'h0, 16'h0);
    rd(0, 0, 8'h00, 64'h0, "R3");

    // arm and count, event selection
    wr(0, 0, 8'h08, 64'h5);
    rd(0, 0, 8'h08, 64'h5, "R2");
    pulse(5, 7, 16'h0, 16'h0, 16'h0);
    rd(0, 0, 8'h00, 64'd7, "R1");
    wr(0, 1, 8'h08, 64'h3);
    pulse(3, 4, 16'h0, 16'h0, 16'h0);
    rd(0, 1, 8'h00, 64'd4, "R1");
    rd(0, 0, 8'h00, 64'd7, "R1");
    wr(0, 3, 8'h08, 64'h9);
    pulse_m('1, 5, 16'h0, 16'h0, 16'h0);
    rd(0, 3, 8'h00, 64'd0, "R1");
    rd(0, 0, 8'h00, 64'd12, "R1");
    rd(0, 1, 8'h00, 64'd9, "R1");

    // disarm
    wr(0, 0, 8'h08, 64'h0);
    pulse(5, 6, 16'h0, 16'h0, 16'h0);
    rd(0, 0, 8'h00, 64'd12, "R3");

    // count not writable
    wr(0, 0, 8'h00, 64'h0);
    rd(0, 0, 8'h00, 64'd12, "R4");
    wr(0, 0, 8'h00, 64'hFFFF);
    rd(0, 0, 8'h00, 64'd12, "R4");

    // filters on slot (1,0)
    wr(1, 0, 8'h08, 64'h5);
    wr(1, 0, 8'h10, 64'h1_FFF0_0120);
    rd(1, 0, 8'h10, 64'h1_FFF0_0120, "R6");
    pulse(5, 3, 16'h0123, 16'h0, 16'h0);
    pulse(5, 2, 16'h0223, 16'h0, 16'h0);
    rd(1, 0, 8'h00, 64'd3, "R5");
    wr(1, 0, 8'h10, 64'h0_FFF0_0120);
    pulse(5, 2, 16'h0223, 16'h0, 16'h0);
    rd(1, 0, 8'h00, 64'd5, "R5");
    wr(1, 0, 8'h18, 64'h1_00F0_0040);
    wr(1, 0, 8'h20, 64'h1_000F_0007);
    pulse(5, 4, 16'h0, 16'h1045, 16'h0007);
    pulse(5, 2, 16'h0, 16'h0050, 16'h0007);
    pulse(5, 2, 16'h0, 16'h0040, 16'h0006);
    rd(1, 0, 8'h00, 64'd9, "R5");
    rd(1, 0, 8'h18, 64'h1_00F0_0040, "R6");
    rd(1, 0, 8'h20, 64'h1_000F_0007, "R6");

    // unmapped offsets
    rd(1, 0, 8'h28, 64'h0, "R7");
    wr(1, 0, 8'h28, 64'hFF);
    rd(1, 0, 8'h08, 64'h5, "R7");

    // out of range, including an index that would alias slot (1,0)
    rd_oor(2, 0);
    rd(1, 0, 8'h08, 64'h5, "R8");
    rd_oor(0, 4);
    wr(0, 4, 8'h08, 64'h0);
    rd(1, 0, 8'h08, 64'h5, "R8");

    // same-cycle write and event
    @(negedge clk);
    req = 1'b1; we = 1'b1; bank = 8'd0; cntr = 8'd2; fn = 8'h08; wdata = 64'h5;
    evt = NE'(1) << 5; rid = '0; pasid = '0; dom = '0;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
    rd(0, 2, 8'h00, 64'd0, "R9");
    pulse(5, 1, 16'h0, 16'h0, 16'h0);
    rd(0, 2, 8'h00, 64'd1, "R9");
    @(negedge clk);
    req = 1'b1; we = 1'b1; bank = 8'd0; cntr = 8'd2; fn = 8'h08; wdata = 64'h0;
    evt = NE'(1) << 5;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
    rd(0, 2, 8'h00, 64'd2, "R9");

    // wrap
    wr(1, 3, 8'h08, 64'h2);
    pulse(2, (1 << CW) + 5, 16'h0, 16'h0, 16'h0);
    rd(1, 3, 8'h00, 64'd5, "R4");

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      int sel;
      @(negedge clk);
      req   = ($urandom % 3) == 0;
      we    = ($urandom % 2) == 0;
      bank  = 8'($urandom % 3);
      cntr  = 8'($urandom % 5);
      sel   = int'($urandom % 6);
      fn    = 8'(sel * 8);
      wdata = {32'($urandom), 32'($urandom)};
      if (fn == 8'h08) wdata[7:0] = 8'($urandom % 10);
      if (fn >= 8'h10) begin
        wdata[15:0]  = 16'($urandom % 4);
        wdata[31:16] = 16'($urandom % 8);
      end
      evt   = NE'($urandom);
      rid   = 16'($urandom % 4);
      pasid = 16'($urandom % 4);
      dom   = 16'($urandom % 4);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
    @(negedge clk);
    finish_run();
  end
endmodule